// File: doc/BRIEF.md
# Audio DMA Address Generator

This block produces the memory addresses for one streaming audio DMA channel. Software programs three things: a start address, an end address equal to the start plus the buffer size, and a page word that holds a 4-bit boundary code. It then sets the channel enable bit. The engine asks for a burst whenever the channel is enabled and the channel FIFO holds at least the threshold amount. Each burst that the bus side grants moves the current pointer forward by the burst size. When the pointer is at the end address, the next granted burst starts again from the start address.

A period event is raised each time a granted burst carries the pointer onto or past an address whose low 5+code bits are zero. That gives a period of 2^(5+code) bytes, from 32 bytes for code 0 up to 1 MB for code 15. The event is held in a sticky status bit. A maskable interrupt line comes from that bit. Software can read the current pointer at any time. A reading equal to the end address means offset zero of the ring.

Top module: `adma_addr_gen`

## Requirements
- R1: After reset the pointer, start address, end address, page word, control word and status all read 0, and `burstReq` and `irq` are low.
- R2: `burstReq` is high only when control bit 0 (enable) is 1 and `fifoLevel` is at least the threshold. The threshold is set by control bits 5:4: code 0 gives 1 dword, code 1 gives 4, code 2 gives 8 and code 3 gives 16.
- R3: A grant (`burstGrant` high while `burstReq` is high) moves the pointer forward by 4·2^b bytes, where b is control bits 3:1. `burstLen` shows 2^b dwords, so the codes 0 to 7 give 1, 2, 4, 8, 16, 32, 64 and 128 dwords.
- R4: A write to the start address register (index 0) also loads the pointer with the written value.
- R5: When the pointer equals the end address (index 1), it can be read back with that value. The next grant sets the pointer to the start address plus one burst step.
- R6: Bits 7:4 of the page word (index 2) hold the limit code L. The status flag sets on any grant whose range, from the starting address (exclusive) to the new pointer (inclusive), contains an address with its low 5+L bits all zero. This includes a burst that ends exactly on an aligned end address. Bit 11 of the page word reads back as written and has no effect on addressing.
- R7: The status flag (index 4, bit 0) stays set until software writes a 1 to it. If a setting grant and a clearing write fall in the same cycle, the flag stays set.
- R8: `irq` equals the status flag AND control bit 6.
- R9: A write to the control register (index 3) updates control bit i, for i in 0..15, only where write-data bit 16+i is 1. All other control bits keep their value.
- R10: Clearing the enable bit drops `burstReq` and leaves the pointer unchanged. Setting it again resumes from the held pointer.
- R11: `burstGrant` while `burstReq` is low leaves the pointer and the flag unchanged.
- R12: Register index 5 reads the current pointer. Indices 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` (combinational) |
| fifoLevel | input | LEVEL_W | Dwords available in the channel FIFO |
| burstGrant | input | 1 | Bus side accepts the requested burst |
| burstReq | output | 1 | Burst request |
| burstLen | output | 8 | Dwords in the requested burst |
| curAddr | output | ADDR_W | Current pointer |
| irq | output | 1 | Period interrupt |

## Verification
Two events can land on the status flag in the same clock edge. A granted burst may cross a period boundary while software writes 1 to clear the flag. The bench brings the pointer to one burst below a 128-byte boundary, then drives the grant and the clearing write together in one cycle. It expects the flag and `irq` to stay high and the pointer to have moved. A second collision comes from clearing the enable bit with a masked control write while a grant is present. This shows the pointer holds once enable is low, and that the other control fields survive the masked write.

// File: rtl/adma_pkg.sv
package adma_pkg;
  localparam int REG_IDX_W = 3;
  localparam logic [REG_IDX_W-1:0] IDX_START  = 3'd0;
  localparam logic [REG_IDX_W-1:0] IDX_END    = 3'd1;
  localparam logic [REG_IDX_W-1:0] IDX_PAGE   = 3'd2;
  localparam logic [REG_IDX_W-1:0] IDX_CTRL   = 3'd3;
  localparam logic [REG_IDX_W-1:0] IDX_STATUS = 3'd4;
  localparam logic [REG_IDX_W-1:0] IDX_PTR    = 3'd5;
  localparam int STEP_W = 10;

  typedef struct packed {
    logic loadStart;
    logic loadEnd;
    logic loadPage;
    logic advance;
    logic clearFlag;
  } dpStrobe_t;
endpackage

// File: rtl/adma_ctrl.sv
module adma_ctrl
  import adma_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LEVEL_W = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [REG_IDX_W-1:0] regAddr,
  input  logic [31:0]          regWrData,
  input  logic [LEVEL_W-1:0]   fifoLevel,
  input  logic                 burstGrant,
  input  logic [ADDR_W-1:0]    startAddr,
  input  logic [ADDR_W-1:0]    endAddr,
  input  logic [ADDR_W-1:0]    ptrAddr,
  input  logic [3:0]           limitCode,
  input  logic                 mmuBit,
  input  logic                 periodFlag,
  output dpStrobe_t            strobe,
  output logic [STEP_W-1:0]    stepBytes,
  output logic                 burstReq,
  output logic [7:0]           burstLen,
  output logic                 irqEn,
  output logic [31:0]          regRdData
);
  logic [15:0] ctrlReg;
  logic [15:0] ctrlNext;
  logic        chanEn;
  logic [2:0]  burstCode;
  logic [1:0]  thrCode;
  logic [LEVEL_W-1:0] thrDwords;

  assign chanEn    = ctrlReg[0];
  assign burstCode = ctrlReg[3:1];
  assign thrCode   = ctrlReg[5:4];
  assign irqEn     = ctrlReg[6];

  always_comb begin
    for (int i = 0; i < 16; i++) begin
      ctrlNext[i] = regWrData[16+i] ? regWrData[i] : ctrlReg[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) ctrlReg <= '0;
    else if (regWrEn && regAddr == IDX_CTRL) ctrlReg <= ctrlNext;
  end

  always_comb begin
    case (thrCode)
      2'd0:    thrDwords = LEVEL_W'(1);
      2'd1:    thrDwords = LEVEL_W'(4);
      2'd2:    thrDwords = LEVEL_W'(8);
      default: thrDwords = LEVEL_W'(16);
    endcase
  end

  assign burstLen  = 8'd1 << burstCode;
  assign stepBytes = STEP_W'(burstLen) << 2;
  assign burstReq  = chanEn && (fifoLevel >= thrDwords);

  always_comb begin
    strobe.loadStart = regWrEn && regAddr == IDX_START;
    strobe.loadEnd   = regWrEn && regAddr == IDX_END;
    strobe.loadPage  = regWrEn && regAddr == IDX_PAGE;
    strobe.clearFlag = regWrEn && regAddr == IDX_STATUS && regWrData[0];
    strobe.advance   = burstReq && burstGrant;
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      IDX_START:  regRdData = 32'(startAddr);
      IDX_END:    regRdData = 32'(endAddr);
      IDX_PAGE:   regRdData = {20'd0, mmuBit, 3'd0, limitCode, 4'd0};
      IDX_CTRL:   regRdData = {16'd0, ctrlReg};
      IDX_STATUS: regRdData = {31'd0, periodFlag};
      IDX_PTR:    regRdData = 32'(ptrAddr);
      default:    regRdData = '0;
    endcase
  end

  // R2: a request is never raised on a disabled channel
  assert_req_needs_enable_R2: assert property (@(posedge clk) disable iff (!rstN)
    burstReq |-> ctrlReg[0]);
  // R11: an accepted burst always had a request behind it
  assert_grant_needs_req_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |-> (burstReq && burstGrant));
  // R9: a control write with an all-zero mask leaves the word unchanged
  assert_masked_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == IDX_CTRL && regWrData[31:16] == 16'd0) |=> $stable(ctrlReg));
endmodule

// File: rtl/adma_datapath.sv
module adma_datapath
  import adma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [31:0]       wrData,
  input  logic [STEP_W-1:0] stepBytes,
  output logic [ADDR_W-1:0] startAddr,
  output logic [ADDR_W-1:0] endAddr,
  output logic [ADDR_W-1:0] ptrAddr,
  output logic [3:0]        limitCode,
  output logic              mmuBit,
  output logic              periodFlag
);
  localparam int SHIFT_W = 5;

  logic [ADDR_W-1:0]  fromAddr;
  logic [ADDR_W-1:0]  toAddr;
  logic [SHIFT_W-1:0] rangeShift;
  logic               atEnd;
  logic               crossing;

  assign atEnd      = (ptrAddr == endAddr);
  assign fromAddr   = atEnd ? startAddr : ptrAddr;
  assign toAddr     = fromAddr + ADDR_W'(stepBytes);
  assign rangeShift = SHIFT_W'(5) + SHIFT_W'(limitCode);
  assign crossing   = (toAddr >> rangeShift) != (fromAddr >> rangeShift);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startAddr <= '0;
      endAddr   <= '0;
      limitCode <= '0;
      mmuBit    <= 1'b0;
    end else begin
      if (strobe.loadStart) startAddr <= ADDR_W'(wrData);
      if (strobe.loadEnd)   endAddr   <= ADDR_W'(wrData);
      if (strobe.loadPage) begin
        limitCode <= wrData[7:4];
        mmuBit    <= wrData[11];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 ptrAddr <= '0;
    else if (strobe.loadStart) ptrAddr <= ADDR_W'(wrData);
    else if (strobe.advance)   ptrAddr <= toAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                              periodFlag <= 1'b0;
    else if (strobe.advance && crossing)    periodFlag <= 1'b1;
    else if (strobe.clearFlag)              periodFlag <= 1'b0;
  end

  // R10: pointer is held unless a burst is granted or the start is reloaded
  assert_ptr_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.advance && !strobe.loadStart) |=> $stable(ptrAddr));
  // R5: at the end address a granted burst restarts from the start address
  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && atEnd && !strobe.loadStart && !strobe.loadEnd)
      |=> ptrAddr == $past(startAddr) + ADDR_W'($past(stepBytes)));
  // R7: flag stays set without a clearing write
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (periodFlag && !strobe.clearFlag) |=> periodFlag);
  // R11: flag never rises without a granted burst
  assert_flag_source_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!periodFlag && !strobe.advance) |=> !periodFlag);
endmodule

// File: rtl/adma_addr_gen.sv
module adma_addr_gen
  import adma_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LEVEL_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [2:0]         regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  input  logic [LEVEL_W-1:0] fifoLevel,
  input  logic               burstGrant,
  output logic               burstReq,
  output logic [7:0]         burstLen,
  output logic [ADDR_W-1:0]  curAddr,
  output logic               irq
);
  dpStrobe_t         strobe;
  logic [STEP_W-1:0] stepBytes;
  logic [ADDR_W-1:0] startAddr;
  logic [ADDR_W-1:0] endAddr;
  logic [ADDR_W-1:0] ptrAddr;
  logic [3:0]        limitCode;
  logic              mmuBit;
  logic              periodFlag;
  logic              irqEn;

  adma_ctrl #(.ADDR_W(ADDR_W), .LEVEL_W(LEVEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .fifoLevel(fifoLevel), .burstGrant(burstGrant),
    .startAddr(startAddr), .endAddr(endAddr), .ptrAddr(ptrAddr),
    .limitCode(limitCode), .mmuBit(mmuBit), .periodFlag(periodFlag),
    .strobe(strobe), .stepBytes(stepBytes), .burstReq(burstReq),
    .burstLen(burstLen), .irqEn(irqEn), .regRdData(regRdData)
  );

  adma_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(regWrData),
    .stepBytes(stepBytes), .startAddr(startAddr), .endAddr(endAddr),
    .ptrAddr(ptrAddr), .limitCode(limitCode), .mmuBit(mmuBit),
    .periodFlag(periodFlag)
  );

  assign curAddr = ptrAddr;
  assign irq     = periodFlag && irqEn;

  // R8: interrupt only with a pending flag
  assert_irq_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> periodFlag);
endmodule

// File: tb/sim_adma_addr_gen.sv
module sim_adma_addr_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [5:0]  fifoLevel = '0;
  logic        burstGrant = 1'b0;
  logic        burstReq;
  logic [7:0]  burstLen;
  logic [31:0] curAddr;
  logic        irq;
  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  adma_addr_gen u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .fifoLevel(fifoLevel),
    .burstGrant(burstGrant), .burstReq(burstReq), .burstLen(burstLen),
    .curAddr(curAddr), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic grant(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      burstGrant = 1'b1;
      @(negedge clk);
      burstGrant = 1'b0;
    end
  endtask

  task automatic test_reset();
    logic [31:0] v;
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), v);
      check("R1 register reset", v, 32'h0);
    end
    check("R1 burstReq reset", {31'd0, burstReq}, 32'h0);
    check("R1 irq reset", {31'd0, irq}, 32'h0);
  endtask

  task automatic test_setup_threshold();
    logic [31:0] v;
    wr(3'd0, 32'h1000);
    wr(3'd1, 32'h1100);
    wr(3'd2, 32'h0000_0020);
    wr(3'd3, 32'h007F_0055);
    rd(3'd5, v);
    check("R4 pointer loaded from start", v, 32'h1000);
    check("R12 curAddr port", curAddr, 32'h1000);
    fifoLevel = 6'd3;
    @(negedge clk);
    check("R2 below threshold no request", {31'd0, burstReq}, 32'h0);
    fifoLevel = 6'd4;
    @(negedge clk);
    check("R2 at threshold request", {31'd0, burstReq}, 32'h1);
    check("R3 burst length 4 dwords", {24'd0, burstLen}, 32'd4);
    rd(3'd6, v);
    check("R12 unused index reads zero", v, 32'h0);
  endtask

  task automatic test_period_and_wrap();
    logic [31:0] v;
    grant(7);
    check("R3 pointer after 7 bursts", curAddr, 32'h1070);
    check("R6 no crossing yet", {31'd0, irq}, 32'h0);
    grant(1);
    check("R6 crossing at 128-byte boundary", {31'd0, irq}, 32'h1);
    wr(3'd4, 32'h1);
    rd(3'd4, v);
    check("R7 write-one clears flag", v, 32'h0);
    grant(8);
    check("R5 pointer shows end address", curAddr, 32'h1100);
    rd(3'd4, v);
    check("R6 aligned end fires", v, 32'h1);
    wr(3'd4, 32'h1);
    grant(1);
    check("R5 wrap to start plus step", curAddr, 32'h1010);
    rd(3'd4, v);
    check("R6 no crossing after wrap", v, 32'h0);
  endtask

  task automatic test_collision();
    logic [31:0] v;
    grant(6);
    check("R3 pointer before collision", curAddr, 32'h1070);
    @(negedge clk);
    burstGrant = 1'b1; regWrEn = 1'b1; regAddr = 3'd4; regWrData = 32'h1;
    @(negedge clk);
    burstGrant = 1'b0; regWrEn = 1'b0;
    check("R7 pointer moved in collision", curAddr, 32'h1080);
    rd(3'd4, v);
    check("R7 set wins over clear", v, 32'h1);
    check("R8 irq follows flag", {31'd0, irq}, 32'h1);
    wr(3'd3, 32'h0040_0000);
    check("R8 irq masked", {31'd0, irq}, 32'h0);
    rd(3'd4, v);
    check("R8 flag kept while masked", v, 32'h1);
    wr(3'd3, 32'h0040_0040);
    check("R8 irq unmasked", {31'd0, irq}, 32'h1);
    wr(3'd4, 32'h1);
  endtask

  task automatic test_enable_hold();
    logic [31:0] v;
    @(negedge clk);
    burstGrant = 1'b1; regWrEn = 1'b1; regAddr = 3'd3; regWrData = 32'h0001_0000;
    @(negedge clk);
    burstGrant = 1'b0; regWrEn = 1'b0;
    check("R10 grant in disabling cycle taken", curAddr, 32'h1090);
    check("R10 request drops", {31'd0, burstReq}, 32'h0);
    rd(3'd3, v);
    check("R9 masked write keeps others", v, 32'h54);
    grant(3);
    check("R11 grant without request ignored", curAddr, 32'h1090);
    rd(3'd4, v);
    check("R11 flag untouched", v, 32'h0);
    wr(3'd3, 32'h0001_0001);
    check("R10 request resumes", {31'd0, burstReq}, 32'h1);
    grant(1);
    check("R10 resume from held pointer", curAddr, 32'h10A0);
  endtask

  task automatic test_big_burst();
    logic [31:0] v;
    wr(3'd2, 32'h0000_0800);
    rd(3'd2, v);
    check("R6 page readback with bit 11", v, 32'h800);
    wr(3'd0, 32'h2000);
    wr(3'd1, 32'h3000);
    wr(3'd3, 32'h003E_000E);
    check("R3 burst length 128 dwords", {24'd0, burstLen}, 32'd128);
    check("R2 threshold 1 met", {31'd0, burstReq}, 32'h1);
    grant(1);
    check("R3 step of 512 bytes", curAddr, 32'h2200);
    rd(3'd4, v);
    check("R6 32-byte range fires", v, 32'h1);
    wr(3'd3, 32'h0030_0030);
    fifoLevel = 6'd15;
    @(negedge clk);
    check("R2 threshold 16 not met", {31'd0, burstReq}, 32'h0);
    fifoLevel = 6'd16;
    @(negedge clk);
    check("R2 threshold 16 met", {31'd0, burstReq}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    test_reset();
    test_setup_threshold();
    test_period_and_wrap();
    test_collision();
    test_enable_hold();
    test_big_burst();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule